// File: doc/BRIEF.md
# Gate Output Steering and Chopping Stage

This block sits between a three-phase PWM timer and the gate drivers of a motor inverter. For each of the phases A, B and C it receives a raw high-side and a raw low-side switching signal. From these it produces the six final gate outputs. Each phase can be crossed over, which swaps its two signals between the high-side and low-side pins. This is the usual way to commutate a brushless DC motor. Each of the six outputs can also be turned off on its own.

For gate drivers that are coupled through a transformer, the block can mix a high-frequency chopping carrier into the outputs. A 10-bit gate word sets the carrier's half-period and selects which side it applies to. The carrier can act on the high side, the low side or both. A shutdown flag forces every output to its inactive level at once.

Software writes the steering word and the gate word at any time. The block copies both into working registers only when the timer's period-start pulse arrives, so a switching period never changes shape partway through.

Top module: `pwm_steer_chop`

## Requirements
- R1: After reset, and until the first period-start pulse, the working steering word has all six disable bits set, so every output is 0 whatever the raw inputs are.
- R2: With no crossover, no disable bit set, no chopping and shutdown low, out_hi[p] equals raw_hi[p] and out_lo[p] equals raw_lo[p] in the same cycle (p = 0 for A, 1 for B, 2 for C).
- R3: When steering bit 6+p is set, phase p is crossed over: out_hi[p] follows raw_lo[p] and out_lo[p] follows raw_hi[p].
- R4: Steering bit 2p set forces out_hi[p] to 0, and bit 2p+1 set forces out_lo[p] to 0. This holds even while the carrier is high. In the full bit order, bits 0 to 5 are AH, AL, BH, BL, CH, CL.
- R5: While shutdown is high, all six outputs are 0 in the same cycle, with no clock edge needed.
- R6: Values on seg_cfg and gate_cfg have no effect on the outputs until a clock edge at which sync is high. From the next cycle on, the new values apply.
- R7: Gate bits [7:0] hold a half-period N. At a sync edge the carrier restarts high. It then stays at each level for N+1 cycles, giving a period of 2(N+1) cycles.
- R8: Gate bit 8 ANDs the carrier onto all high-side outputs, and gate bit 9 ANDs it onto all low-side outputs. Either bit, both bits or neither can be set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync | input | 1 | Period-start pulse from the PWM timer |
| seg_cfg | input | 3*PHASES | Steering word: per-output disables, per-phase crossovers |
| gate_cfg | input | HALF_W+2 | Chopping half-period and side enables |
| raw_hi | input | PHASES | Raw high-side phase signals |
| raw_lo | input | PHASES | Raw low-side phase signals |
| shutdown | input | 1 | Forces all outputs inactive |
| out_hi | output | PHASES | Final high-side gate outputs |
| out_lo | output | PHASES | Final low-side gate outputs |

## Verification
The bench builds the block with its default sizes: three phases and an 8-bit half-period field. It programs chopping half-periods of 0, 1 and 2, so several complete carrier periods fit in a handful of cycles. This lets the bench check the restart at sync, the N+1 dwell at each level and the choice of side. The 9-bit steering word is short enough to test single disables, disables combined with chopping, and crossover on one phase and on all three. The bench also rewrites both words without a sync to show that nothing changes until the pulse arrives.

// File: rtl/pwm_steer_pkg.sv
package pwm_steer_pkg;

  typedef enum logic {
    SIDE_HI = 1'b0,
    SIDE_LO = 1'b1
  } side_e;

  // Position of the disable bit for one output inside the steering word
  function automatic int unsigned dis_bit(input int unsigned phase, input side_e side);
    return 2 * phase + ((side == SIDE_LO) ? 1 : 0);
  endfunction

endpackage

// File: rtl/steer_shadow.sv
module steer_shadow #(
  parameter int unsigned SEG_W   = 9,
  parameter int unsigned GATE_W  = 10,
  parameter logic [SEG_W-1:0] SEG_RST = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [SEG_W-1:0]  seg_in,
  input  logic [GATE_W-1:0] gate_in,
  output logic [SEG_W-1:0]  seg_q,
  output logic [GATE_W-1:0] gate_q
);

  logic [SEG_W-1:0]  seg_d;
  logic [GATE_W-1:0] gate_d;

  always_comb begin
    seg_d  = seg_q;
    gate_d = gate_q;
    if (load) begin
      seg_d  = seg_in;
      gate_d = gate_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q  <= SEG_RST;
      gate_q <= '0;
    end else begin
      seg_q  <= seg_d;
      gate_q <= gate_d;
    end
  end

endmodule

// File: rtl/chop_carrier.sv
module chop_carrier #(
  parameter int unsigned HALF_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic [HALF_W-1:0] half,
  output logic              carrier
);

  logic [HALF_W-1:0] cnt_q, cnt_d;
  logic              car_q, car_d;
  logic              at_end;

  assign at_end = (cnt_q == half);

  always_comb begin
    cnt_d = cnt_q;
    car_d = car_q;
    if (restart) begin
      cnt_d = '0;
      car_d = 1'b1;
    end else if (at_end) begin
      cnt_d = '0;
      car_d = ~car_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      car_q <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      car_q <= car_d;
    end
  end

  assign carrier = car_q;

endmodule

// File: rtl/steer_lane.sv
module steer_lane (
  input  logic raw_h,
  input  logic raw_l,
  input  logic xover,
  input  logic dis_h,
  input  logic dis_l,
  input  logic chop_h,
  input  logic chop_l,
  input  logic carrier,
  input  logic shutdown,
  output logic out_h,
  output logic out_l
);

  logic sel_h, sel_l;
  logic gate_h, gate_l;

  always_comb begin
    sel_h  = xover ? raw_l : raw_h;
    sel_l  = xover ? raw_h : raw_l;
    gate_h = chop_h ? carrier : 1'b1;
    gate_l = chop_l ? carrier : 1'b1;
    out_h  = sel_h & gate_h & ~dis_h & ~shutdown;
    out_l  = sel_l & gate_l & ~dis_l & ~shutdown;
  end

endmodule

// File: rtl/pwm_steer_chop.sv
module pwm_steer_chop #(
  parameter int unsigned PHASES = 3,
  parameter int unsigned HALF_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sync,
  input  logic [3*PHASES-1:0]   seg_cfg,
  input  logic [HALF_W+1:0]     gate_cfg,
  input  logic [PHASES-1:0]     raw_hi,
  input  logic [PHASES-1:0]     raw_lo,
  input  logic                  shutdown,
  output logic [PHASES-1:0]     out_hi,
  output logic [PHASES-1:0]     out_lo
);

  localparam int unsigned SEG_W  = 3 * PHASES;
  localparam int unsigned GATE_W = HALF_W + 2;
  localparam int unsigned XO_LSB = 2 * PHASES;
  localparam int unsigned CH_HI  = HALF_W;
  localparam int unsigned CH_LO  = HALF_W + 1;
  localparam logic [SEG_W-1:0] SEG_RST = {{PHASES{1'b0}}, {(2*PHASES){1'b1}}};

  logic [SEG_W-1:0]  act_seg;
  logic [GATE_W-1:0] act_gate;
  logic              carrier;

  steer_shadow #(
    .SEG_W  (SEG_W),
    .GATE_W (GATE_W),
    .SEG_RST(SEG_RST)
  ) u_shadow (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (sync),
    .seg_in (seg_cfg),
    .gate_in(gate_cfg),
    .seg_q  (act_seg),
    .gate_q (act_gate)
  );

  chop_carrier #(
    .HALF_W(HALF_W)
  ) u_carrier (
    .clk    (clk),
    .rst_n  (rst_n),
    .restart(sync),
    .half   (act_gate[HALF_W-1:0]),
    .carrier(carrier)
  );

  for (genvar p = 0; p < PHASES; p++) begin : g_lane
    localparam int unsigned HI_IDX = pwm_steer_pkg::dis_bit(p, pwm_steer_pkg::SIDE_HI);
    localparam int unsigned LO_IDX = pwm_steer_pkg::dis_bit(p, pwm_steer_pkg::SIDE_LO);

    steer_lane u_lane (
      .raw_h   (raw_hi[p]),
      .raw_l   (raw_lo[p]),
      .xover   (act_seg[XO_LSB + p]),
      .dis_h   (act_seg[HI_IDX]),
      .dis_l   (act_seg[LO_IDX]),
      .chop_h  (act_gate[CH_HI]),
      .chop_l  (act_gate[CH_LO]),
      .carrier (carrier),
      .shutdown(shutdown),
      .out_h   (out_hi[p]),
      .out_l   (out_lo[p])
    );
  end

endmodule

// File: rtl/pwm_steer_chop_chk.sv
module pwm_steer_chop_chk #(
  parameter int unsigned PHASES = 3,
  parameter int unsigned HALF_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                sync,
  input logic                shutdown,
  input logic [PHASES-1:0]   out_hi,
  input logic [PHASES-1:0]   out_lo,
  input logic [3*PHASES-1:0] act_seg,
  input logic [HALF_W+1:0]   act_gate,
  input logic                carrier
);

  // R5
  sd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |-> (out_hi == '0 && out_lo == '0));

  // R6
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sync |=> ($stable(act_seg) && $stable(act_gate)));

  // R7
  car_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync |=> carrier);

  // R8
  hi_chop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_gate[HALF_W] && !carrier) |-> (out_hi == '0));

  // R8
  lo_chop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_gate[HALF_W+1] && !carrier) |-> (out_lo == '0));

  for (genvar p = 0; p < PHASES; p++) begin : g_dis
    // R4
    hi_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      act_seg[2*p] |-> !out_hi[p]);
    // R4
    lo_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      act_seg[2*p+1] |-> !out_lo[p]);
  end

endmodule

bind pwm_steer_chop pwm_steer_chop_chk #(
  .PHASES(PHASES),
  .HALF_W(HALF_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .sync    (sync),
  .shutdown(shutdown),
  .out_hi  (out_hi),
  .out_lo  (out_lo),
  .act_seg (act_seg),
  .act_gate(act_gate),
  .carrier (carrier)
);

// File: tb/sim_pwm_steer_chop.sv
`timescale 1ns/100ps
module sim_pwm_steer_chop;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       sync;
  logic [8:0] seg_cfg;
  logic [9:0] gate_cfg;
  logic [2:0] raw_hi, raw_lo;
  logic       shutdown;
  logic [2:0] out_hi, out_lo;

  always #2.5 clk = ~clk;

  pwm_steer_chop u0 (
    .clk(clk), .rst_n(rst_n), .sync(sync), .seg_cfg(seg_cfg), .gate_cfg(gate_cfg),
    .raw_hi(raw_hi), .raw_lo(raw_lo), .shutdown(shutdown),
    .out_hi(out_hi), .out_lo(out_lo)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [5:0] exp_q[$];
  string      tag_q[$];

  // Requirement model state (as of the most recent clock edge)
  logic [8:0] m_seg  = 9'h03F;
  logic [9:0] m_gate = '0;
  logic [7:0] m_cnt  = '0;
  logic       m_car  = 1'b1;

  function automatic logic [5:0] model(input logic [2:0] h, input logic [2:0] l, input logic sd);
    logic [5:0] r;
    for (int p = 0; p < 3; p++) begin
      logic sh, sl;
      sh = m_seg[6+p] ? l[p] : h[p];
      sl = m_seg[6+p] ? h[p] : l[p];
      r[2*p]   = sh & ~m_seg[2*p]   & ~sd & (m_gate[8] ? m_car : 1'b1);
      r[2*p+1] = sl & ~m_seg[2*p+1] & ~sd & (m_gate[9] ? m_car : 1'b1);
    end
    return r;
  endfunction

  // Driver: called at a falling edge, applies inputs, pushes the expected outputs
  task automatic step(input logic s, input logic [8:0] sg, input logic [9:0] gt,
                      input logic [2:0] h, input logic [2:0] l, input logic sd, input string tag);
    sync = s; seg_cfg = sg; gate_cfg = gt; raw_hi = h; raw_lo = l; shutdown = sd;
    exp_q.push_back(model(h, l, sd));
    tag_q.push_back(tag);
    if (s) begin
      m_seg = sg; m_gate = gt; m_cnt = '0; m_car = 1'b1;
    end else if (m_cnt == m_gate[7:0]) begin
      m_cnt = '0; m_car = ~m_car;
    end else begin
      m_cnt = m_cnt + 8'd1;
    end
    @(negedge clk);
  endtask

  // Monitor: samples combinational outputs mid-cycle and compares
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (exp_q.size() > 0) begin
        logic [5:0] e, a;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        a = {out_lo[2], out_hi[2], out_lo[1], out_hi[1], out_lo[0], out_hi[0]};
        checks++;
        if (a !== e) begin
          fails++;
          $display("FAIL %s: outputs {CL,CH,BL,BH,AL,AH} actual %b expected %b", t, a, e);
        end
      end
    end
  end

  initial begin
    #500000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sync = 0; seg_cfg = '0; gate_cfg = '0; raw_hi = '0; raw_lo = '0; shutdown = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: all outputs off after reset
    step(0, 9'h000, 10'h000, 3'b111, 3'b111, 0, "R1");
    step(0, 9'h000, 10'h000, 3'b101, 3'b010, 0, "R1");
    // R6: new word ignored without sync
    step(0, 9'h000, 10'h000, 3'b111, 3'b000, 0, "R6");
    step(1, 9'h000, 10'h000, 3'b111, 3'b000, 0, "R6");
    // R2: pass-through patterns
    step(0, 9'h000, 10'h000, 3'b101, 3'b010, 0, "R2");
    step(0, 9'h000, 10'h000, 3'b010, 3'b101, 0, "R2");
    step(0, 9'h000, 10'h000, 3'b110, 3'b001, 0, "R2");
    // R3: crossover on A only, then all phases
    step(0, 9'h040, 10'h000, 3'b001, 3'b000, 0, "R6");
    step(1, 9'h040, 10'h000, 3'b001, 3'b000, 0, "R3");
    step(0, 9'h040, 10'h000, 3'b001, 3'b000, 0, "R3");
    step(0, 9'h040, 10'h000, 3'b000, 3'b011, 0, "R3");
    step(1, 9'h1C0, 10'h000, 3'b101, 3'b010, 0, "R3");
    step(0, 9'h1C0, 10'h000, 3'b101, 3'b010, 0, "R3");
    // R4: AH and CL disabled
    step(1, 9'h021, 10'h000, 3'b111, 3'b111, 0, "R4");
    step(0, 9'h021, 10'h000, 3'b111, 3'b111, 0, "R4");
    step(0, 9'h021, 10'h000, 3'b011, 3'b110, 0, "R4");
    // R5: shutdown clears everything at once
    step(1, 9'h000, 10'h000, 3'b111, 3'b111, 0, "R5");
    step(0, 9'h000, 10'h000, 3'b111, 3'b111, 1, "R5");
    step(0, 9'h000, 10'h000, 3'b111, 3'b111, 0, "R5");
    // R7 R8: high-side chopping with N=2
    step(1, 9'h000, 10'h102, 3'b111, 3'b111, 0, "R7");
    for (int i = 0; i < 14; i++) step(0, 9'h000, 10'h102, 3'b111, 3'b111, 0, "R7");
    // R8: low-side only, N=0
    step(1, 9'h000, 10'h200, 3'b111, 3'b111, 0, "R8");
    for (int i = 0; i < 6; i++) step(0, 9'h000, 10'h200, 3'b111, 3'b111, 0, "R8");
    // R8: both sides, N=1, with crossover on B
    step(1, 9'h080, 10'h301, 3'b101, 3'b010, 0, "R8");
    for (int i = 0; i < 8; i++) step(0, 9'h080, 10'h301, 3'b101, 3'b010, 0, "R8");
    // R4: disabled outputs stay off under chopping; R5 shutdown with chopping
    step(1, 9'h012, 10'h300, 3'b111, 3'b111, 0, "R4");
    for (int i = 0; i < 4; i++) step(0, 9'h012, 10'h300, 3'b111, 3'b111, 0, "R4");
    step(0, 9'h012, 10'h300, 3'b111, 3'b111, 1, "R5");
    // R6: change gate word without sync, carrier keeps old timing
    for (int i = 0; i < 4; i++) step(0, 9'h000, 10'h107, 3'b111, 3'b111, 0, "R6");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule